// File: doc/BRIEF.md
# Overcurrent Cycle Blanking with Exponential Backoff

This block enforces a cycle-by-cycle current limit on a switching converter. At each switching-cycle boundary it looks at an overcurrent comparator result for the cycle that is ending. If the cycle was conducting and the comparator tripped, the block withdraws the high-side drive permit for a number of upcoming switching cycles. It then restores the permit.

The blanking length starts at one cycle. It doubles each time the first conducting cycle after a blank trips again: 1, 2, 4, 8, and then 16 cycles. At 16 it stops growing, and every further trip repeats a 16-cycle blank. One conducting cycle that ends without a trip sets the length back to one. The comparator is not consulted during blanked cycles, because the switch is off then.

The sensing circuit, the trip threshold and the gate drivers sit outside the block. The block sees a one-clock cycle-start strobe and the comparator level, which it samples on that strobe.

Top module: `ocp_backoff`

## Requirements
- R1: While reset is low, and after it is released, `hs_permit` is 1 and `blank_cnt` is 0. A blank in progress is abandoned, and the next trip blanks one cycle.
- R2: A strobe with `oc_flag` high while `blank_cnt` is 0 (a conducting cycle) makes `blank_cnt` equal the current blank length in the next clock, with `hs_permit` 0. The first trip after reset gives 1.
- R3: Each strobe while `blank_cnt` is nonzero lowers `blank_cnt` by exactly 1. The permit is therefore low for exactly N strobes during a blank of length N.
- R4: When the first conducting cycle after a blank trips again, the length is doubled, giving 1, 2, 4, 8, 16 on consecutive trips.
- R5: The blank length never exceeds 2^MAX_SHIFT (16 by default). Trips after that keep blanking 16 cycles.
- R6: A strobe with `oc_flag` low while `blank_cnt` is 0 leaves `blank_cnt` at 0 and returns the length to 1 for the next trip.
- R7: `oc_flag` at strobes during a blank neither extends the blank nor changes the length used after it.
- R8: Without a strobe, `blank_cnt` and `hs_permit` hold their values whatever `oc_flag` does.
- R9: `hs_permit` is 1 exactly when `blank_cnt` is 0. `blank_cnt` is the plain binary count of blanked cycles still to come, including the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe at each switching-cycle boundary |
| oc_flag | input | 1 | Overcurrent comparator result for the cycle ending at the strobe |
| hs_permit | output | 1 | High-side drive allowed for the current cycle |
| blank_cnt | output | MAX_SHIFT+1 | Blanked cycles remaining, binary |

## Verification
The assertions take `cyc_start` to be a single-clock pulse, with no two strobes on adjacent clocks. They also take `oc_flag` to matter only in the clock where the strobe is high, and they reason from `blank_cnt` at that edge alone.

The stimulus drives every input at the falling edge. Each strobe lasts exactly one clock and is followed by at least one idle clock. `oc_flag` is deliberately left high across idle clocks and across blanked strobes, to show that those samples are ignored.

// File: rtl/ocp_backoff.sv
module ocp_backoff #(
  parameter int MAX_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_start,
  input  logic               oc_flag,
  output logic               hs_permit,
  output logic [MAX_SHIFT:0] blank_cnt
);
  localparam int CW = MAX_SHIFT + 1;

  logic [CW-1:0] len_oh;
  logic [CW-1:0] remain;

  wire conducting = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_oh <= CW'(1);
      remain <= '0;
    end else if (cyc_start) begin
      if (!conducting) begin
        remain <= remain - 1'b1;
      end else if (oc_flag) begin
        remain <= len_oh;
        if (!len_oh[CW-1]) len_oh <= len_oh << 1;
      end else begin
        len_oh <= CW'(1);
      end
    end
  end

  assign hs_permit = conducting;
  assign blank_cnt = remain;
endmodule

module ocp_backoff_chk #(
  parameter int MAX_SHIFT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_start,
  input logic               oc_flag,
  input logic               hs_permit,
  input logic [MAX_SHIFT:0] blank_cnt
);
  localparam logic [MAX_SHIFT:0] CAP = {1'b1, {MAX_SHIFT{1'b0}}};

  assert_hold_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> ($stable(blank_cnt) && $stable(hs_permit)));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && blank_cnt != '0) |=> (blank_cnt == $past(blank_cnt) - 1'b1));

  assert_trip_power_of_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && blank_cnt == '0 && oc_flag) |=> ($countones(blank_cnt) == 1 && !hs_permit));

  assert_clean_stays_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && blank_cnt == '0 && !oc_flag) |=> (blank_cnt == '0 && hs_permit));

  assert_length_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blank_cnt <= CAP);
endmodule

bind ocp_backoff ocp_backoff_chk #(.MAX_SHIFT(MAX_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .oc_flag(oc_flag),
  .hs_permit(hs_permit), .blank_cnt(blank_cnt)
);

// File: tb/sim_ocp_backoff.sv
`timescale 1ns/1ps
module sim_ocp_backoff;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic oc_flag = 1'b0;
  logic hs_permit;
  logic [4:0] blank_cnt;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ocp_backoff #(.MAX_SHIFT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .oc_flag(oc_flag),
    .hs_permit(hs_permit), .blank_cnt(blank_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req, input int cnt);
    check(req, blank_cnt, cnt);
    check(req, hs_permit, (cnt == 0) ? 1 : 0);
  endtask

  task automatic strobe(input logic flag);
    cyc_start = 1'b1;
    oc_flag = flag;
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic blank_of(input string req, input int n, input logic noise);
    int low = 0;
    strobe(1'b1);
    expect_state(req, n);
    for (int k = 1; k <= n; k++) begin
      if (!hs_permit) low++;
      strobe(noise);
      expect_state({req, " R3 R7"}, n - k);
    end
    check({req, " R3 low strobes"}, low, n);
  endtask

  task automatic t_reset_R1;
    @(negedge clk);
    expect_state("R1 in reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1 after release", 0);
  endtask

  task automatic t_first_trip_R2;
    blank_of("R2 first trip", 1, 1'b0);
  endtask

  task automatic t_ladder_R4_R5;
    strobe(1'b0);
    expect_state("R6 clean", 0);
    for (int i = 0; i < 7; i++)
      blank_of((i < 5) ? "R4 ladder" : "R5 cap", (i < 4) ? (1 << i) : 16, 1'b1);
  endtask

  task automatic t_clean_reset_R6;
    strobe(1'b0);
    expect_state("R6 clean after cap", 0);
    blank_of("R6 length back to 1", 1, 1'b0);
    blank_of("R6 then 2", 2, 1'b0);
    strobe(1'b0);
  endtask

  task automatic t_no_strobe_R8;
    oc_flag = 1'b1;
    repeat (6) @(negedge clk);
    expect_state("R8 idle flag high", 0);
    strobe(1'b1);
    expect_state("R8 trip", 1);
    oc_flag = 1'b1;
    repeat (5) @(negedge clk);
    expect_state("R8 blank held", 1);
    strobe(1'b0);
    expect_state("R8 blank done", 0);
    check("R9 permit", hs_permit, 1);
  endtask

  task automatic t_reset_mid_R1;
    strobe(1'b1);
    expect_state("R1 pre", 2);
    rst_n = 1'b0;
    @(negedge clk);
    expect_state("R1 mid-blank reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    blank_of("R1 length after reset", 1, 1'b0);
  endtask

  initial begin
    t_reset_R1();
    t_first_trip_R2();
    t_ladder_R4_R5();
    t_clean_reset_R6();
    t_no_strobe_R8();
    t_reset_mid_R1();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule